// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits beside one processor's cache controller and provides the bookkeeping for a load-linked / store-conditional pair on a snooping bus. A load-linked records a reservation on the cache block that holds the loaded word. The cache supplies the data; the monitor only tracks the reservation. Any event that could let another agent change that block removes the reservation. Such events are a write-type bus transaction from another cache, an eviction of the block, or an ordinary store by this processor.

A store-conditional either fails immediately, or requests the bus and waits. It fails immediately, without touching the bus, when the reservation is gone or names a different block. When it waits, a grant completes it. The monitor then returns a success flag and issues a one-cycle write strobe with the stored word. If a write-type snoop to the block arrives first, another agent won the race. The store then fails with no write and no bus transaction. The reservation is dropped after every store-conditional, whatever its outcome. Software retries from the load-linked.

Top module: `resv_monitor`

## Requirements
- R1: After reset the reservation is invalid, bus_req is low, and sc_done, sc_ok and sc_wr_en are low.
- R2: An operation with op_kind 2 (load-linked) makes resv_valid high and resv_blk equal to op_addr shifted right by OFFW (6 by default) one cycle later. It replaces any earlier reservation.
- R3: An operation with op_kind 3 (store-conditional) is accepted when resv_valid is high, the block of op_addr equals resv_blk, and nothing clears the reservation in that cycle. bus_req is then high from the next cycle on, with bus_addr equal to op_addr, and it stays high until the store completes or fails.
- R4: A store-conditional that is not accepted fails at once. In the next cycle sc_done is 1, sc_ok is 0 and sc_wr_en is 0, and bus_req is never raised for it.
- R5: A bus_gnt seen while bus_req is high gives, one cycle later, a single-cycle pulse with sc_done=1, sc_ok=1 and sc_wr_en=1. sc_wr_addr and sc_wr_data carry the accepted address and data.
- R6: A snoop with snoop_kind 1 (read-exclusive), 2 (upgrade) or 3 (update) to the reserved block clears the reservation. snoop_kind 0 (read) has no effect. While bus_req is high, such a clearing snoop makes the store fail one cycle later (sc_done=1, sc_ok=0, no write) and drops bus_req.
- R7: An ordinary store (op_kind 1) to the reserved block clears the reservation. A load (op_kind 0) has no effect.
- R8: An eviction (evict_valid) of the reserved block clears the reservation. Evicting another block has no effect.
- R9: In the cycle sc_done is high, resv_valid is low, whether the store succeeded or failed.
- R10: While bus_req is high, processor operations of every kind are ignored.
- R11: Same-cycle priority: a load-linked takes effect over a clearing event in the same cycle. A clearing event beats both acceptance of a store-conditional and a bus grant in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Processor operation present |
| op_kind | input | 2 | 0 load, 1 store, 2 load-linked, 3 store-conditional |
| op_addr | input | AW | Operation address |
| op_wdata | input | DW | Store-conditional data |
| snoop_valid | input | 1 | Snooped bus transaction from another agent |
| snoop_kind | input | 2 | 0 read, 1 read-exclusive, 2 upgrade, 3 update |
| snoop_addr | input | AW | Snooped address |
| evict_valid | input | 1 | Cache evicts a block |
| evict_addr | input | AW | Evicted address |
| bus_gnt | input | 1 | Bus granted to this processor |
| bus_req | output | 1 | Bus request for a pending store-conditional |
| bus_addr | output | AW | Address of the pending store-conditional |
| sc_done | output | 1 | Store-conditional finished (one cycle) |
| sc_ok | output | 1 | Condition result, 1 success, 0 failure |
| sc_wr_en | output | 1 | Write strobe to the cache |
| sc_wr_addr | output | AW | Write address |
| sc_wr_data | output | DW | Write data |
| resv_valid | output | 1 | Reservation held |
| resv_blk | output | AW-OFFW | Reserved block number |

## Verification
Every result is registered exactly once. A reservation change, a request, an immediate failure, a grant outcome or a lost race shows up on the outputs in the cycle after the edge that sampled its cause. The bench drives inputs on the falling edge and lets the rising edge latch them. It then advances its own reference model by one step and compares all outputs shortly after that edge. Each comparison is matched to the stimulus of exactly one cycle, both in the directed corner cases and in the random stretch.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LL    = 2'd2,
    OP_SC    = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    SN_READ = 2'd0,
    SN_RDX  = 2'd1,
    SN_UPGR = 2'd2,
    SN_UPD  = 2'd3
  } snoop_kind_e;

  // A snooped transaction can change the data only if it is not a plain read.
  function automatic logic snoop_writes(input logic [1:0] kind);
    return kind != SN_READ;
  endfunction
endpackage

// File: rtl/resv_kill.sv
module resv_kill #(
  parameter int BW = 26
) (
  input  logic          rv,
  input  logic [BW-1:0] rb,
  input  logic          snoop_valid,
  input  logic [1:0]    snoop_kind,
  input  logic [BW-1:0] snoop_blk,
  input  logic          evict_valid,
  input  logic [BW-1:0] evict_blk,
  input  logic          st_valid,
  input  logic [BW-1:0] st_blk,
  output logic          hit_snoop,
  output logic          hit_evict,
  output logic          hit_store,
  output logic          kill
);
  import resv_pkg::*;

  always_comb begin
    hit_snoop = rv && snoop_valid && snoop_writes(snoop_kind) && (snoop_blk == rb);
    hit_evict = rv && evict_valid && (evict_blk == rb);
    hit_store = rv && st_valid && (st_blk == rb);
    kill      = hit_snoop || hit_evict || hit_store;
  end
endmodule

// File: rtl/resv_store.sv
module resv_store #(
  parameter int BW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic [BW-1:0] set_blk,
  input  logic          clr,
  output logic          valid,
  output logic [BW-1:0] blk
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      blk   <= '0;
    end else if (set) begin
      valid <= 1'b1;
      blk   <= set_blk;
    end else if (clr) begin
      valid <= 1'b0;
    end
  end

  assert_ll_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> (valid && blk == $past(set_blk)));

  assert_clear_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !valid);
endmodule

// File: rtl/sc_seq.sv
module sc_seq #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sc_req,
  input  logic          sc_can,
  input  logic          kill,
  input  logic          gnt,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          waiting,
  output logic          done,
  output logic          ok,
  output logic          wr_en,
  output logic [AW-1:0] hold_addr,
  output logic [DW-1:0] hold_data,
  output logic          fail_now,
  output logic          seq_clr
);
  always_comb begin
    fail_now = !waiting && sc_req && !sc_can;
    seq_clr  = fail_now || (waiting && gnt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting   <= 1'b0;
      done      <= 1'b0;
      ok        <= 1'b0;
      wr_en     <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
    end else begin
      done  <= 1'b0;
      ok    <= 1'b0;
      wr_en <= 1'b0;
      if (!waiting) begin
        if (sc_req) begin
          if (sc_can) begin
            waiting   <= 1'b1;
            hold_addr <= addr;
            hold_data <= data;
          end else begin
            done <= 1'b1;
          end
        end
      end else if (kill) begin
        waiting <= 1'b0;
        done    <= 1'b1;
      end else if (gnt) begin
        waiting <= 1'b0;
        done    <= 1'b1;
        ok      <= 1'b1;
        wr_en   <= 1'b1;
      end
    end
  end

  assert_fail_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fail_now |=> (done && !ok && !waiting && !wr_en));

  assert_write_only_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (done && ok));

  assert_grant_writes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && gnt && !kill) |=> wr_en);

  assert_lost_race_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && kill) |=> (done && !ok && !wr_en));

  assert_wait_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |=> (waiting || done));
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int OFFW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [1:0]         op_kind,
  input  logic [AW-1:0]      op_addr,
  input  logic [DW-1:0]      op_wdata,
  input  logic               snoop_valid,
  input  logic [1:0]         snoop_kind,
  input  logic [AW-1:0]      snoop_addr,
  input  logic               evict_valid,
  input  logic [AW-1:0]      evict_addr,
  input  logic               bus_gnt,
  output logic               bus_req,
  output logic [AW-1:0]      bus_addr,
  output logic               sc_done,
  output logic               sc_ok,
  output logic               sc_wr_en,
  output logic [AW-1:0]      sc_wr_addr,
  output logic [DW-1:0]      sc_wr_data,
  output logic               resv_valid,
  output logic [AW-OFFW-1:0] resv_blk
);
  import resv_pkg::*;

  localparam int BW = AW - OFFW;

  logic          waiting;
  logic          idle;
  logic          op_ll, op_sc, op_st;
  logic [BW-1:0] op_blk, snoop_blk, evict_blk;
  logic          hit_snoop, hit_evict, hit_store, kill;
  logic          sc_can, fail_now, seq_clr, resv_clr;
  logic [AW-1:0] hold_addr;
  logic [DW-1:0] hold_data;

  always_comb begin
    idle      = !waiting;
    op_blk    = op_addr[AW-1:OFFW];
    snoop_blk = snoop_addr[AW-1:OFFW];
    evict_blk = evict_addr[AW-1:OFFW];
    op_ll     = idle && op_valid && (op_kind == OP_LL);
    op_sc     = idle && op_valid && (op_kind == OP_SC);
    op_st     = idle && op_valid && (op_kind == OP_STORE);
    sc_can    = resv_valid && (resv_blk == op_blk) && !kill;
    resv_clr  = kill || seq_clr;
  end

  resv_kill #(.BW(BW)) u_kill (
    .rv          (resv_valid),
    .rb          (resv_blk),
    .snoop_valid (snoop_valid),
    .snoop_kind  (snoop_kind),
    .snoop_blk   (snoop_blk),
    .evict_valid (evict_valid),
    .evict_blk   (evict_blk),
    .st_valid    (op_st),
    .st_blk      (op_blk),
    .hit_snoop   (hit_snoop),
    .hit_evict   (hit_evict),
    .hit_store   (hit_store),
    .kill        (kill)
  );

  resv_store #(.BW(BW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (op_ll),
    .set_blk (op_blk),
    .clr     (resv_clr),
    .valid   (resv_valid),
    .blk     (resv_blk)
  );

  sc_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sc_req    (op_sc),
    .sc_can    (sc_can),
    .kill      (kill),
    .gnt       (bus_gnt),
    .addr      (op_addr),
    .data      (op_wdata),
    .waiting   (waiting),
    .done      (sc_done),
    .ok        (sc_ok),
    .wr_en     (sc_wr_en),
    .hold_addr (hold_addr),
    .hold_data (hold_data),
    .fail_now  (fail_now),
    .seq_clr   (seq_clr)
  );

  always_comb begin
    bus_req    = waiting;
    bus_addr   = hold_addr;
    sc_wr_addr = hold_addr;
    sc_wr_data = hold_data;
  end

  assert_done_drops_resv_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sc_done |-> !resv_valid);

  assert_req_holds_resv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> resv_valid);

  assert_read_snoop_harmless_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (resv_valid && idle && !op_valid && !evict_valid && snoop_valid &&
     snoop_kind == SN_READ) |=> resv_valid);

  assert_busy_ignores_ops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !kill && !bus_gnt) |=> (bus_req && $stable(bus_addr)));
endmodule

// File: tb/resv_monitor_tb.sv
module resv_monitor_tb;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [1:0]    op_kind = 2'd0;
  logic [AW-1:0] op_addr = '0;
  logic [DW-1:0] op_wdata = '0;
  logic          snoop_valid = 1'b0;
  logic [1:0]    snoop_kind = 2'd0;
  logic [AW-1:0] snoop_addr = '0;
  logic          evict_valid = 1'b0;
  logic [AW-1:0] evict_addr = '0;
  logic          bus_gnt = 1'b0;
  logic          bus_req, sc_done, sc_ok, sc_wr_en, resv_valid;
  logic [AW-1:0] bus_addr, sc_wr_addr;
  logic [DW-1:0] sc_wr_data;
  logic [25:0]   resv_blk;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  // reference model state
  bit            m_rv, m_wait, m_done, m_ok, m_wr;
  logic [25:0]   m_rb;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_data;

  always #10 clk = ~clk;

  resv_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_addr(op_addr), .op_wdata(op_wdata), .snoop_valid(snoop_valid),
    .snoop_kind(snoop_kind), .snoop_addr(snoop_addr), .evict_valid(evict_valid),
    .evict_addr(evict_addr), .bus_gnt(bus_gnt), .bus_req(bus_req),
    .bus_addr(bus_addr), .sc_done(sc_done), .sc_ok(sc_ok), .sc_wr_en(sc_wr_en),
    .sc_wr_addr(sc_wr_addr), .sc_wr_data(sc_wr_data), .resv_valid(resv_valid),
    .resv_blk(resv_blk)
  );

  function automatic logic [25:0] blk_of(input logic [31:0] a);
    return 26'(a / 64);
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit kill;
    kill = m_rv && ((snoop_valid && snoop_kind != 2'd0 && blk_of(snoop_addr) == m_rb) ||
                    (evict_valid && blk_of(evict_addr) == m_rb) ||
                    (!m_wait && op_valid && op_kind == 2'd1 && blk_of(op_addr) == m_rb));
    m_done = 0; m_ok = 0; m_wr = 0;
    if (m_wait) begin
      if (kill) begin
        m_done = 1; m_rv = 0; m_wait = 0;
      end else if (bus_gnt) begin
        m_done = 1; m_ok = 1; m_wr = 1; m_rv = 0; m_wait = 0;
      end
    end else if (op_valid && op_kind == 2'd2) begin
      m_rv = 1; m_rb = blk_of(op_addr);
    end else if (op_valid && op_kind == 2'd3) begin
      if (m_rv && m_rb == blk_of(op_addr) && !kill) begin
        m_wait = 1; m_addr = op_addr; m_data = op_wdata;
      end else begin
        m_done = 1; m_rv = 0;
      end
    end else if (kill) begin
      m_rv = 0;
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "R2 resv_valid", 64'(resv_valid), 64'(m_rv));
    if (m_rv) chk(tag, "R2 resv_blk", 64'(resv_blk), 64'(m_rb));
    chk(tag, "R3 bus_req", 64'(bus_req), 64'(m_wait));
    if (m_wait) chk(tag, "R3 bus_addr", 64'(bus_addr), 64'(m_addr));
    chk(tag, "R4 sc_done", 64'(sc_done), 64'(m_done));
    chk(tag, "R5 sc_ok", 64'(sc_ok), 64'(m_ok));
    chk(tag, "R5 sc_wr_en", 64'(sc_wr_en), 64'(m_wr));
    if (m_wr) begin
      chk(tag, "R5 sc_wr_addr", 64'(sc_wr_addr), 64'(m_addr));
      chk(tag, "R5 sc_wr_data", 64'(sc_wr_data), 64'(m_data));
    end
  endtask

  task automatic cyc(input string tag, input logic ov, input logic [1:0] ok,
                     input logic [31:0] oa, input logic [31:0] od,
                     input logic sv, input logic [1:0] sk, input logic [31:0] sa,
                     input logic ev, input logic [31:0] ea, input logic g);
    @(negedge clk);
    op_valid = ov; op_kind = ok; op_addr = oa; op_wdata = od;
    snoop_valid = sv; snoop_kind = sk; snoop_addr = sa;
    evict_valid = ev; evict_addr = ea; bus_gnt = g;
    @(posedge clk);
    model_step();
    #1;
    compare(tag);
  endtask

  task automatic nop(input string tag);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  localparam logic [31:0] A  = 32'h100;
  localparam logic [31:0] A2 = 32'h13C;
  localparam logic [31:0] B  = 32'h200;

  initial begin
    void'($urandom(32'd20240611));
    m_rv = 0; m_wait = 0; m_done = 0; m_ok = 0; m_wr = 0; m_rb = '0;
    m_addr = '0; m_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    compare("R1 reset state");

    cyc("R2 ll sets", 1, 2, A, 0, 0, 0, 0, 0, 0, 0);
    cyc("R2 ll replaces", 1, 2, B, 0, 0, 0, 0, 0, 0, 0);
    cyc("R4 sc wrong block", 1, 3, A, 32'h11, 0, 0, 0, 0, 0, 0);
    nop("R4 no request after fail");

    cyc("R2 ll again", 1, 2, A, 0, 0, 0, 0, 0, 0, 0);
    cyc("R3 sc accepted same block", 1, 3, A2, 32'hCAFE, 0, 0, 0, 0, 0, 0);
    cyc("R10 ll ignored while waiting", 1, 2, B, 0, 0, 0, 0, 0, 0, 0);
    cyc("R10 store ignored while waiting", 1, 1, A, 0, 0, 0, 0, 0, 0, 0);
    cyc("R6 read snoop harmless", 0, 0, 0, 0, 1, 0, A, 0, 0, 0);
    cyc("R5 grant succeeds", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    nop("R9 resv gone after success");

    cyc("R7 ll", 1, 2, A, 0, 0, 0, 0, 0, 0, 0);
    cyc("R7 load harmless", 1, 0, A, 0, 0, 0, 0, 0, 0, 0);
    cyc("R7 own store clears", 1, 1, A2, 0, 0, 0, 0, 0, 0, 0);
    cyc("R4 sc after store fails", 1, 3, A, 1, 0, 0, 0, 0, 0, 0);

    cyc("R6 ll", 1, 2, A, 0, 0, 0, 0, 0, 0, 0);
    cyc("R6 sc waits", 1, 3, A, 32'h55, 0, 0, 0, 0, 0, 0);
    cyc("R6 lost race to upgrade", 0, 0, 0, 0, 1, 2, A2, 0, 0, 0);
    nop("R6 no write after loss");

    cyc("R8 ll", 1, 2, A, 0, 0, 0, 0, 0, 0, 0);
    cyc("R8 other evict harmless", 0, 0, 0, 0, 0, 0, 0, 1, B, 0);
    cyc("R8 evict clears", 0, 0, 0, 0, 0, 0, 0, 1, A, 0);

    cyc("R11 ll beats rdx", 1, 2, A, 0, 1, 1, A, 0, 0, 0);
    cyc("R11 update beats sc", 1, 3, A, 7, 1, 3, A, 0, 0, 0);
    cyc("R11 ll", 1, 2, B, 0, 0, 0, 0, 0, 0, 0);
    cyc("R11 sc waits", 1, 3, B, 9, 0, 0, 0, 0, 0, 0);
    cyc("R11 rdx beats grant", 0, 0, 0, 0, 1, 1, B, 0, 0, 1);
    nop("R9 after loss");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] oa, sa, ea;
      oa = 32'(($urandom % 3) * 64 + ($urandom % 16) * 4);
      sa = 32'(($urandom % 3) * 64);
      ea = 32'(($urandom % 3) * 64);
      cyc("R2 R3 R5 R6 random", ($urandom % 3) != 0, 2'($urandom), oa, $urandom,
          ($urandom % 4) == 0, 2'($urandom), sa, ($urandom % 12) == 0, ea,
          m_wait && (($urandom % 3) == 0));
    end
    summary();
  end
endmodule